// File: doc/BRIEF.md
# Splittable Event Performance Counter Unit

This unit counts hardware events for performance analysis. It holds four physical counters. Each one runs either as a single 32-bit counter or as two independent 16-bit halves, which gives up to eight logical counters. A 64-line event bus feeds the unit. Each logical counter picks one line from that bus. It can invert the line, count only its rising edges, or ignore the line and count clock cycles.

Software drives the unit through a synchronous register port. A global control word turns the monitor on. The same word freezes all counters, picks saturation or wrap at the maximum value, splits individual physical counters into halves, and restricts counting to one privilege level, which the unit compares against a live privilege-mode input. When a counter passes its all-ones value it latches an overflow flag. Reading the status word clears the flags. A mask selects which flags raise the interrupt output.

Top module: `evt_ctr_unit`

## Requirements
- R1: After reset, every register reads zero, every counter reads zero and `irq` is low.
- R2: Register map, with the address in `reg_addr`:
  - 0x00 is the global control word.
  - 0x01 is the status word.
  - 0x02 is the interrupt mask.
  - 0x08+c is the control word of logical counter c.
  - 0x10+c is the value of logical counter c.
  In a counter control word, bits 31:26 select the event line and bit 22 enables the counter. By default the counter adds one in every cycle in which its event line is high.
- R3: Bit 24 of a counter control word inverts the selected event line before counting.
- R4: Bit 23 of a counter control word makes the counter add one on every enabled cycle, whatever the event line does.
- R5: Bit 25 of a counter control word makes the counter add one only on a rising edge of the event line, taken after any inversion.
- R6: Global bit (24 − p) splits physical counter p into two 16-bit halves. Logical counter p is the low half and logical counter p+4 is the high half. The halves count independently, with no carry between them, and each reads back zero-extended. When physical counter p is not split, logical counter p reads all 32 bits, logical counter p+4 reads zero, and the control word of p+4 has no effect.
- R7: At the all-ones value of its width, a counter that is asked to increment sets its overflow flag. It then stays at all-ones if global bit 30 is set, and wraps to zero if that bit is clear.
- R8: A counter increments only while global bit 31 is set, global bit 20 (freeze) is clear and its own enable bit is set.
- R9: Global bits 19:18 choose the privilege mode that is counted: 0, 1 and 2 must equal the `priv_mode` input, and 3 counts in every mode.
- R10: The overflow flag of logical counter c reads at status bit (31 − c). A status read returns the flags and clears them at the same clock edge.
- R11: `irq` is high while any overflow flag c is set whose mask bit c (mask register bit c) is set.
- R12: A counter write takes effect at the next clock edge and overrides an increment at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed only for the status clear) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_bus | input | 64 | Event lines |
| priv_mode | input | 2 | Current privilege mode |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The bench builds the unit with its default parameters: four physical counters and a 64-line event bus. At these values every control-word bit position, every status bit from 31 down to 24, and all 64 event selections can be reached.

A seeded random stream on the event bus drives three counters at once: one in level mode, one inverted, and one counting edges. The bench keeps its own tally of what each should reach.

Counters are preloaded near all-ones so that both the 16-bit and the 32-bit boundaries are crossed in a few cycles. This covers wrap, saturation, and the absence of carry between split halves.

// File: rtl/evt_pkg.sv
// Package for the event counter unit: register geometry, field bit
// positions and address decode constants.
// Assumes a 32-bit register word and at most four physical counters.
package evt_pkg;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int ADDR_W = 5;

    // global control word fields
    localparam int GC_EN        = 31;
    localparam int GC_SAT       = 30;
    localparam int GC_SPLIT_TOP = 24;
    localparam int GC_FRZ       = 20;
    localparam int GC_MODE_LO   = 18;

    // per-counter control word fields
    localparam int CC_SEL_LO = 26;
    localparam int CC_EDGE   = 25;
    localparam int CC_POL    = 24;
    localparam int CC_CYC    = 23;
    localparam int CC_EN     = 22;

    // address decode: region in addr[4:3], index in addr[2:0]
    localparam logic [1:0] RG_GLOB = 2'd0;
    localparam logic [1:0] RG_CCTL = 2'd1;
    localparam logic [1:0] RG_CNT  = 2'd2;
    localparam logic [2:0] IX_GCTL = 3'd0;
    localparam logic [2:0] IX_STAT = 3'd1;
    localparam logic [2:0] IX_MASK = 3'd2;

    // privilege filter: mode 3 accepts every level
    function automatic logic priv_ok(input logic [1:0] sel_mode, input logic [1:0] cur);
        return (sel_mode == 2'd3) || (sel_mode == cur);
    endfunction
endpackage

// File: rtl/evt_select.sv
// Event qualifier for one logical counter. It picks one event line,
// applies polarity and either level, rising-edge or cycle counting, and
// reports whether this cycle is a countable hit.
// Assumes sel is in range for EVT_W lines.
module evt_select #(
    parameter int EVT_W = 64,
    localparam int SEL_W = $clog2(EVT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_bus,
    input  logic [SEL_W-1:0] sel,
    input  logic             pol,
    input  logic             edge_mode,
    input  logic             cyc_mode,
    output logic             hit
);
    logic lvl;
    logic prev_q;

    // polarity-adjusted level of the selected line
    always_comb lvl = evt_bus[sel] ^ pol;

    // remember last level for edge detection, updated every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // choose the counting rule
    always_comb begin
        if (cyc_mode)       hit = 1'b1;
        else if (edge_mode) hit = lvl & ~prev_q;
        else                hit = lvl;
    end
endmodule

// File: rtl/ctr_phys.sv
// One physical counter that is either a full-width counter or two
// independent half-width counters. A write to a part wins over an
// increment of that part. An overflow pulse is raised whenever an
// increment is requested at the all-ones value.
// Assumes the write strobes match the current split setting.
module ctr_phys #(
    parameter int HW = 16,
    localparam int W = 2 * HW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         split,
    input  logic         sat,
    input  logic         inc_lo,
    input  logic         inc_hi,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic         wr_full,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         ovf_lo,
    output logic         ovf_hi
);
    localparam logic [HW-1:0] ONE_H = HW'(1);
    localparam logic [W-1:0]  ONE_W = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] nxt;

    // next-state: loads first, then increment with wrap or saturate
    always_comb begin
        nxt    = cnt_q;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        if (split) begin
            if (wr_lo) begin
                nxt[HW-1:0] = wdata[HW-1:0];
            end else if (inc_lo) begin
                if (&cnt_q[HW-1:0]) begin
                    ovf_lo = 1'b1;
                    if (!sat) nxt[HW-1:0] = '0;
                end else begin
                    nxt[HW-1:0] = cnt_q[HW-1:0] + ONE_H;
                end
            end
            if (wr_hi) begin
                nxt[W-1:HW] = wdata[HW-1:0];
            end else if (inc_hi) begin
                if (&cnt_q[W-1:HW]) begin
                    ovf_hi = 1'b1;
                    if (!sat) nxt[W-1:HW] = '0;
                end else begin
                    nxt[W-1:HW] = cnt_q[W-1:HW] + ONE_H;
                end
            end
        end else begin
            if (wr_full) begin
                nxt = wdata;
            end else if (inc_lo) begin
                if (&cnt_q) begin
                    ovf_lo = 1'b1;
                    if (!sat) nxt = '0;
                end else begin
                    nxt = cnt_q + ONE_W;
                end
            end
        end
    end

    // counter state register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= nxt;
    end

    always_comb value = cnt_q;
endmodule

// File: rtl/evt_ctr_unit.sv
// Event performance counter unit: four physical counters, each
// splittable into two halves, eight logical counters with their own
// event selection, global gating, overflow status and masked interrupt.
// Assumes a 32-bit register word, NPHYS <= 4, EVT_W <= 64. Read data is
// combinational; only a status read has a side effect (clear).
module evt_ctr_unit #(
    parameter int NPHYS = 4,
    parameter int EVT_W = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [evt_pkg::ADDR_W-1:0] reg_addr,
    input  logic [evt_pkg::DATA_W-1:0] reg_wdata,
    output logic [evt_pkg::DATA_W-1:0] reg_rdata,
    input  logic [EVT_W-1:0]           evt_bus,
    input  logic [1:0]                 priv_mode,
    output logic                       irq
);
    import evt_pkg::*;

    localparam int NLOG  = 2 * NPHYS;
    localparam int SEL_W = $clog2(EVT_W);

    logic [DATA_W-1:0] gctl_q;
    logic [DATA_W-1:0] cctl_q   [NLOG];
    logic [DATA_W-1:0] phys_val [NPHYS];
    logic [DATA_W-1:0] cnt_rd   [NLOG];
    logic [DATA_W-1:0] stat_vec;
    logic [NLOG-1:0]   mask_q, ovf_flags, ovf_pulse, hit, inc;
    logic [NPHYS-1:0]  split;
    logic [1:0]        region;
    logic [2:0]        idx;
    logic              gate, cnt_wr, stat_rd;

    // address split into region and index
    always_comb begin
        region  = reg_addr[4:3];
        idx     = reg_addr[2:0];
        cnt_wr  = reg_wr && (region == RG_CNT);
        stat_rd = reg_rd && (region == RG_GLOB) && (idx == IX_STAT);
    end

    // global counting gate: enable, no freeze, privilege match
    always_comb gate = gctl_q[GC_EN] & ~gctl_q[GC_FRZ]
                     & priv_ok(gctl_q[GC_MODE_LO +: 2], priv_mode);

    // global control and interrupt mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gctl_q <= '0;
            mask_q <= '0;
        end else if (reg_wr && region == RG_GLOB) begin
            if (idx == IX_GCTL) gctl_q <= reg_wdata;
            if (idx == IX_MASK) mask_q <= reg_wdata[NLOG-1:0];
        end
    end

    // per-counter control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NLOG; c++) cctl_q[c] <= '0;
        end else if (reg_wr && region == RG_CCTL && int'(idx) < NLOG) begin
            cctl_q[idx] <= reg_wdata;
        end
    end

    // event qualification and increment requests per logical counter
    for (genvar c = 0; c < NLOG; c++) begin : g_log
        evt_select #(.EVT_W(EVT_W)) u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_bus   (evt_bus),
            .sel       (cctl_q[c][CC_SEL_LO +: SEL_W]),
            .pol       (cctl_q[c][CC_POL]),
            .edge_mode (cctl_q[c][CC_EDGE]),
            .cyc_mode  (cctl_q[c][CC_CYC]),
            .hit       (hit[c])
        );
        if (c < NPHYS) begin : g_lo
            always_comb inc[c] = gate & cctl_q[c][CC_EN] & hit[c];
        end else begin : g_hi
            always_comb inc[c] = gate & cctl_q[c][CC_EN] & hit[c] & split[c-NPHYS];
        end
    end

    // physical counters and their read views
    for (genvar p = 0; p < NPHYS; p++) begin : g_phys
        always_comb split[p] = gctl_q[GC_SPLIT_TOP - p];

        ctr_phys #(.HW(HALF_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .split   (split[p]),
            .sat     (gctl_q[GC_SAT]),
            .inc_lo  (inc[p]),
            .inc_hi  (inc[p+NPHYS]),
            .wr_lo   (cnt_wr && idx == 3'(p) && split[p]),
            .wr_hi   (cnt_wr && idx == 3'(p + NPHYS) && split[p]),
            .wr_full (cnt_wr && idx == 3'(p) && !split[p]),
            .wdata   (reg_wdata),
            .value   (phys_val[p]),
            .ovf_lo  (ovf_pulse[p]),
            .ovf_hi  (ovf_pulse[p+NPHYS])
        );

        always_comb begin
            cnt_rd[p]       = split[p] ? {{HALF_W{1'b0}}, phys_val[p][HALF_W-1:0]} : phys_val[p];
            cnt_rd[p+NPHYS] = split[p] ? {{HALF_W{1'b0}}, phys_val[p][DATA_W-1:HALF_W]} : '0;
        end
    end

    // sticky overflow flags, cleared by a status read, new pulses win
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_flags <= '0;
        else        ovf_flags <= (stat_rd ? '0 : ovf_flags) | ovf_pulse;
    end

    // status word: counter c reported at bit (DATA_W-1-c)
    always_comb begin
        stat_vec = '0;
        for (int c = 0; c < NLOG; c++) stat_vec[DATA_W-1-c] = ovf_flags[c];
    end

    // read data multiplexer
    always_comb begin
        reg_rdata = '0;
        case (region)
            RG_GLOB: begin
                if (idx == IX_GCTL) reg_rdata = gctl_q;
                if (idx == IX_STAT) reg_rdata = stat_vec;
                if (idx == IX_MASK) reg_rdata = {{(DATA_W-NLOG){1'b0}}, mask_q};
            end
            RG_CCTL: if (int'(idx) < NLOG) reg_rdata = cctl_q[idx];
            RG_CNT:  if (int'(idx) < NLOG) reg_rdata = cnt_rd[idx];
            default: reg_rdata = '0;
        endcase
    end

    // masked interrupt
    always_comb irq = |(ovf_flags & mask_q);
endmodule

// File: rtl/evt_ctr_chk.sv
// Assertion checker for evt_ctr_unit, bound to the top module.
// Watches physical counter 0, the global gate bits and the flag register.
module evt_ctr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [4:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        g_en,
    input logic        g_sat,
    input logic        g_split0,
    input logic        g_frz,
    input logic [31:0] phys0,
    input logic [7:0]  flags
);
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (g_frz && !reg_wr) |=> $stable(phys0)); // R8
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_en && !reg_wr) |=> $stable(phys0)); // R8
    AST_SAT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (g_sat && !g_split0 && (&phys0) && !reg_wr) |=> (&phys0)); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 5'h10 && !g_split0) |=> (phys0 == $past(reg_wdata))); // R12
    AST_FLAG_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & ~$past(flags))) |-> $past(g_en && !g_frz)); // R10
endmodule

bind evt_ctr_unit evt_ctr_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .g_en      (gctl_q[31]),
    .g_sat     (gctl_q[30]),
    .g_split0  (gctl_q[24]),
    .g_frz     (gctl_q[20]),
    .phys0     (phys_val[0]),
    .flags     (ovf_flags)
);

// File: tb/test_evt_ctr_unit.sv
// Bench for evt_ctr_unit: directed corner cases plus a seeded random
// event stream checked against tallies computed here.
module test_evt_ctr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] evt_bus = '0;
    logic [1:0]  priv_mode = 2'd0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    localparam logic [31:0] G_EN  = 32'h8000_0000;
    localparam logic [31:0] G_ALL = 32'h000C_0000; // mode 3
    localparam logic [31:0] G_SAT = 32'h4000_0000;
    localparam logic [31:0] G_FRZ = 32'h0010_0000;

    evt_ctr_unit i_evt_ctr_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_bus(evt_bus), .priv_mode(priv_mode), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] cc(input int sel, input bit edg, input bit pol,
                                       input bit cyc, input bit en);
        return (32'(sel) << 26) | (32'(edg) << 25) | (32'(pol) << 24)
             | (32'(cyc) << 23) | (32'(en) << 22);
    endfunction

    function automatic bit lvl_of(input logic [63:0] bus, input int sel, input bit pol);
        return bus[sel] ^ pol;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reinit();
        logic [31:0] junk;
        wr(5'h00, '0);
        for (int c = 0; c < 8; c++) wr(5'(8 + c), '0);
        for (int c = 0; c < 8; c++) wr(5'(16 + c), '0);
        wr(5'h02, '0);
        rd(5'h01, junk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int sa, sb, sc, ea, eb, ec;
        bit prev_c, cur_c;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 chk("R1 irq", 32'(irq), 0);
        rd(5'h00, v); chk("R1 gctl", v, 0);
        rd(5'h10, v); chk("R1 cnt0", v, 0);
        rd(5'h01, v); chk("R1 status", v, 0);
        rd(5'h0B, v); chk("R1 cctl3", v, 0);

        // R2 level counting of line 5
        reinit();
        wr(5'h08, cc(5, 0, 0, 0, 1));
        wr(5'h00, G_EN | G_ALL);
        evt_bus[5] = 1'b1; idle(7); evt_bus[5] = 1'b0; idle(1);
        wr(5'h00, 0);
        rd(5'h10, v); chk("R2 level count", v, 7);

        // R3 inverted polarity on line 9
        reinit();
        evt_bus = '1;
        wr(5'h09, cc(9, 0, 1, 0, 1));
        wr(5'h00, G_EN | G_ALL);
        idle(3); evt_bus[9] = 1'b0; idle(4); evt_bus[9] = 1'b1;
        wr(5'h00, 0);
        evt_bus = '0;
        rd(5'h11, v); chk("R3 inverted count", v, 4);

        // R4 cycle counting
        reinit();
        wr(5'h0A, cc(0, 0, 0, 1, 1));
        wr(5'h00, G_EN | G_ALL); idle(5); wr(5'h00, 0);
        rd(5'h12, v); chk("R4 cycle count", v, 6);

        // R5 rising-edge counting
        reinit();
        wr(5'h0B, cc(12, 1, 0, 0, 1));
        wr(5'h00, G_EN | G_ALL);
        evt_bus[12] = 1'b1; idle(3); evt_bus[12] = 1'b0; idle(2);
        evt_bus[12] = 1'b1; idle(1); evt_bus[12] = 1'b0; idle(1);
        wr(5'h00, 0);
        rd(5'h13, v); chk("R5 edge count", v, 2);

        // R9 privilege filter: mode 1
        reinit();
        wr(5'h08, cc(0, 0, 0, 1, 1));
        priv_mode = 2'd0;
        wr(5'h00, G_EN | 32'h0004_0000); idle(4); wr(5'h00, 0);
        rd(5'h10, v); chk("R9 mismatch no count", v, 0);
        priv_mode = 2'd1;
        wr(5'h00, G_EN | 32'h0004_0000); idle(4); wr(5'h00, 0);
        rd(5'h10, v); chk("R9 match counts", v, 5);
        priv_mode = 2'd0;

        // R8 freeze and per-counter enable
        reinit();
        wr(5'h08, cc(0, 0, 0, 1, 1));
        wr(5'h09, cc(0, 0, 0, 1, 0));
        wr(5'h00, G_EN | G_ALL | G_FRZ); idle(4); wr(5'h00, 0);
        rd(5'h10, v); chk("R8 frozen", v, 0);
        wr(5'h00, G_EN | G_ALL); idle(2); wr(5'h00, 0);
        rd(5'h10, v); chk("R8 enabled counts", v, 3);
        rd(5'h11, v); chk("R8 counter disabled", v, 0);

        // R6 split halves, R7 16-bit wrap, R10 status bit 31 and clear
        reinit();
        wr(5'h00, 32'h0100_0000);
        wr(5'h10, 32'h0000_FFFE);
        wr(5'h14, 32'h0000_0005);
        wr(5'h08, cc(0, 0, 0, 1, 1));
        wr(5'h0C, cc(0, 0, 0, 1, 1));
        wr(5'h00, G_EN | G_ALL | 32'h0100_0000); idle(2); wr(5'h00, 32'h0100_0000);
        rd(5'h10, v); chk("R6 R7 low half wrapped", v, 1);
        rd(5'h14, v); chk("R6 high half no carry", v, 8);
        rd(5'h01, v); chk("R10 status bit31", v, 32'h8000_0000);
        rd(5'h01, v); chk("R10 status cleared", v, 0);

        // R6 unsplit: high logical counter ignored and reads zero
        reinit();
        wr(5'h0C, cc(0, 0, 0, 1, 1));
        wr(5'h00, G_EN | G_ALL); idle(3); wr(5'h00, 0);
        rd(5'h10, v); chk("R6 unsplit low untouched", v, 0);
        rd(5'h14, v); chk("R6 unsplit high reads zero", v, 0);

        // R7 32-bit wrap, R11 masked interrupt
        reinit();
        wr(5'h12, 32'hFFFF_FFFF);
        wr(5'h0A, cc(0, 0, 0, 1, 1));
        wr(5'h02, 32'h4);
        wr(5'h00, G_EN | G_ALL); wr(5'h00, 0);
        rd(5'h12, v); chk("R7 32-bit wrap", v, 0);
        #1 chk("R11 irq set", 32'(irq), 1);
        wr(5'h02, 32'h0);
        #1 chk("R11 irq masked", 32'(irq), 0);
        wr(5'h02, 32'h4);
        rd(5'h01, v); chk("R7 R10 status bit29", v, 32'h2000_0000);
        #1 chk("R11 irq after clear", 32'(irq), 0);

        // R7 saturation at 32-bit max
        reinit();
        wr(5'h11, 32'hFFFF_FFFE);
        wr(5'h09, cc(0, 0, 0, 1, 1));
        wr(5'h00, G_EN | G_ALL | G_SAT); idle(2); wr(5'h00, 0);
        rd(5'h11, v); chk("R7 saturated", v, 32'hFFFF_FFFF);
        rd(5'h01, v); chk("R7 saturation flag", v, 32'h4000_0000);

        // R12 write beats increment
        reinit();
        wr(5'h08, cc(0, 0, 0, 1, 1));
        wr(5'h00, G_EN | G_ALL); idle(3);
        wr(5'h10, 32'd100);
        rd(5'h10, v); chk("R12 write wins", v, 100);
        wr(5'h00, 0);

        // R2 R3 R5 seeded random event stream
        reinit();
        sa = int'($urandom % 64); sb = int'($urandom % 64); sc = int'($urandom % 64);
        wr(5'h08, cc(sa, 0, 0, 0, 1));
        wr(5'h09, cc(sb, 0, 1, 0, 1));
        wr(5'h0A, cc(sc, 1, 0, 0, 1));
        wr(5'h00, G_EN | G_ALL);
        ea = 0; eb = 0; ec = 0; prev_c = 1'b0;
        for (int i = 0; i < 300; i++) begin
            evt_bus = {$urandom, $urandom};
            ea += int'(lvl_of(evt_bus, sa, 0));
            eb += int'(lvl_of(evt_bus, sb, 1));
            cur_c = lvl_of(evt_bus, sc, 0);
            ec += int'(cur_c & ~prev_c);
            prev_c = cur_c;
            @(negedge clk);
        end
        evt_bus = '0;
        eb += 1;
        wr(5'h00, 0);
        rd(5'h10, v); chk("R2 random level", v, 32'(ea));
        rd(5'h11, v); chk("R3 random inverted", v, 32'(eb));
        rd(5'h12, v); chk("R5 random edges", v, 32'(ec));

        finish_run();
    end
endmodule